// File: doc/BRIEF.md
# Amplifier Fault and Mute Controller

This block supervises the power stage of a two-channel switching amplifier. It watches a signed die-temperature code, a raw over-current comparator flag, an active-low power-down request and an active-low mute request. From these it decides when the output stage may switch, and it reports three active-low error indications: thermal warning, thermal shutdown and over-current.

Thermal faults follow a hysteresis band. Two rising trip points set the warning and the shutdown. A single lower release point clears both, and the stage then restarts without outside help. An over-current event has to be seen on consecutive synchronised samples before it counts. Once it counts, it stays latched until the power-down input is asserted or mute is pulled and then let go. A power-down request only counts if it stays low for a minimum number of cycles. After it is released, the stage stays quiet for a programmable settling delay. Each time the stage is enabled, the block emits a single-cycle start request for the external pop-suppression ramp.

Top module: `amp_guard`

## Requirements
- R1: `err_warn_n` goes low two cycles after `temp_c` is strictly greater than `T_WARN` (signed degrees). A value equal to `T_WARN` does not trip it.
- R2: `err_shut_n` goes low two cycles after `temp_c` is strictly greater than `T_SHUT`, and `stage_en` is low one cycle later.
- R3: Once tripped, `err_warn_n` and `err_shut_n` return high only two cycles after `temp_c` is strictly below `T_CLR`.
- R4: While `temp_c` stays anywhere from `T_CLR` up to `T_WARN` inclusive, both thermal outputs keep their state.
- R5: `oc_flag` is synchronised through two flops and must be high on `OC_CONFIRM` consecutive synchronised samples. With the default of 2, `err_oc_n` falls four cycles after `oc_flag` rises. A one-cycle pulse never trips it.
- R6: A latched over-current holds `err_oc_n` low and `stage_en` low, even after `oc_flag` drops. It clears three cycles after `mute_n` returns high, but only if `mute_n` went low while the fault was latched.
- R7: An accepted power-down clears the over-current latch.
- R8: `pdn_n` is accepted only when it is low for at least `RST_MIN_CYC` consecutive cycles. A shorter low pulse leaves `stage_en` unchanged.
- R9: After an accepted power-down is released, `stage_en` stays low for `UNMUTE_DLY_CYC + 3` cycles and rises one cycle later, even if `mute_n` is already high.
- R10: `stage_en` goes low three cycles after `mute_n` goes low. This is well inside the 5 µs budget (`MUTE_MAX_CYC`).
- R11: `pop_start` is high for exactly one cycle, in the cycle in which `stage_en` rises, and at no other time.
- R12: While `arst_n` is low and just after it is released, all three error outputs are high and `stage_en` and `pop_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 × sample rate) |
| arst_n | input | 1 | Asynchronous block reset, active low |
| temp_c | input | TEMP_W | Signed die temperature in °C |
| oc_flag | input | 1 | Raw over-current comparator flag, active high |
| pdn_n | input | 1 | Power-down request, active low |
| mute_n | input | 1 | Mute request, active low |
| err_warn_n | output | 1 | Thermal warning, active low |
| err_shut_n | output | 1 | Thermal shutdown, active low |
| err_oc_n | output | 1 | Latched over-current, active low |
| stage_en | output | 1 | Output stage enable |
| pop_start | output | 1 | One-cycle start request for the pop-suppression ramp |

## Verification
The bench builds the block with `UNMUTE_DLY_CYC` = 40 instead of one second of clock cycles. This puts the full power-down, settle and enable sequence, including its exact cycle boundary, within a short run. `RST_MIN_CYC` stays at 6, so the accept/reject boundary of the power-down filter is tested at 5 and 6 cycles. The temperature thresholds keep their defaults of 135, 150 and 120, so the equal-to-threshold and negative-temperature cases are tested against the real trip points.

// File: rtl/amp_guard_pkg.sv
`timescale 1ns/1ps
package amp_guard_pkg;

   localparam int SYNC_DEPTH = 2;

   typedef struct packed {
      logic warn;
      logic shut;
   } therm_flags_t;

   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/amp_sync.sv
`timescale 1ns/1ps
module amp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   if (STAGES < 2) begin : g_bad
      $error("amp_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sh[0] <= RST_VAL;
            else         sh[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sh[i] <= RST_VAL;
            else         sh[i] <= sh[i-1];
         end
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/amp_thermal.sv
`timescale 1ns/1ps
module amp_thermal
   import amp_guard_pkg::*;
#(
   parameter int TEMP_W = 9,
   parameter int T_WARN = 135,
   parameter int T_SHUT = 150,
   parameter int T_CLR  = 120
) (
   input  logic                     clk,
   input  logic                     arst_n,
   input  logic signed [TEMP_W-1:0] temp_c,
   output therm_flags_t             flags
);
   logic signed [TEMP_W-1:0] temp_q;
   logic                     below_clr;

   assign below_clr = (temp_q < T_CLR);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         temp_q <= '0;
         flags  <= '0;
      end else begin
         temp_q <= temp_c;
         if (below_clr) begin
            flags.warn <= 1'b0;
            flags.shut <= 1'b0;
         end else begin
            if (temp_q > T_WARN) flags.warn <= 1'b1;
            if (temp_q > T_SHUT) flags.shut <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/amp_rst_qual.sv
`timescale 1ns/1ps
module amp_rst_qual
   import amp_guard_pkg::*;
#(
   parameter int MIN_LOW = 6
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pdn_n,
   output logic rst_act
);
   localparam int CW = cnt_w(MIN_LOW);

   logic          pdn_s;
   logic [CW-1:0] low_cnt;

   amp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .arst_n(arst_n), .d(pdn_n), .q(pdn_s)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         low_cnt <= '0;
         rst_act <= 1'b1;
      end else if (pdn_s) begin
         low_cnt <= '0;
         rst_act <= 1'b0;
      end else begin
         if (low_cnt != CW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
         if (low_cnt == CW'(MIN_LOW - 1)) rst_act <= 1'b1;
      end
   end
endmodule

// File: rtl/amp_oc_guard.sv
`timescale 1ns/1ps
module amp_oc_guard
   import amp_guard_pkg::*;
#(
   parameter int CONFIRM = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic oc_flag,
   input  logic rst_act,
   input  logic mute_act,
   output logic oc_lat
);
   logic oc_s;
   logic seen;
   logic armed;

   amp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .arst_n(arst_n), .d(oc_flag), .q(oc_s)
   );

   if (CONFIRM == 2) begin : g_pair
      logic hist;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) hist <= 1'b0;
         else         hist <= oc_s;
      end
      assign seen = oc_s & hist;
   end else begin : g_wide
      logic [CONFIRM-2:0] hist;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) hist <= '0;
         else         hist <= {hist[CONFIRM-3:0], oc_s};
      end
      assign seen = oc_s & (&hist);
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         oc_lat <= 1'b0;
         armed  <= 1'b0;
      end else if (rst_act) begin
         oc_lat <= 1'b0;
         armed  <= 1'b0;
      end else if (oc_lat) begin
         if (armed && !mute_act) begin
            oc_lat <= 1'b0;
            armed  <= 1'b0;
         end else begin
            armed <= armed | mute_act;
         end
      end else begin
         oc_lat <= seen;
         armed  <= 1'b0;
      end
   end
endmodule

// File: rtl/amp_stage_seq.sv
`timescale 1ns/1ps
module amp_stage_seq
   import amp_guard_pkg::*;
#(
   parameter int DLY = 11289600
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_act,
   input  logic mute_act,
   input  logic oc_lat,
   input  logic shut,
   output logic stage_en,
   output logic pop_start
);
   localparam int CW = cnt_w(DLY);

   logic [CW-1:0] dly_cnt;
   logic          settled;
   logic          en_next;

   assign settled = (dly_cnt == CW'(DLY));
   assign en_next = !rst_act && settled && !mute_act && !oc_lat && !shut;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         dly_cnt <= '0;
      end else if (rst_act) begin
         dly_cnt <= '0;
      end else if (!settled) begin
         dly_cnt <= dly_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         stage_en  <= 1'b0;
         pop_start <= 1'b0;
      end else begin
         stage_en  <= en_next;
         pop_start <= en_next & ~stage_en;
      end
   end
endmodule

// File: rtl/amp_guard.sv
`timescale 1ns/1ps
module amp_guard
   import amp_guard_pkg::*;
#(
   parameter int TEMP_W         = 9,
   parameter int T_WARN         = 135,
   parameter int T_SHUT         = 150,
   parameter int T_CLR          = 120,
   parameter int OC_CONFIRM     = 2,
   parameter int RST_MIN_CYC    = 6,
   parameter int UNMUTE_DLY_CYC = 11289600,
   parameter int MUTE_MAX_CYC   = 56
) (
   input  logic                     clk,
   input  logic                     arst_n,
   input  logic signed [TEMP_W-1:0] temp_c,
   input  logic                     oc_flag,
   input  logic                     pdn_n,
   input  logic                     mute_n,
   output logic                     err_warn_n,
   output logic                     err_shut_n,
   output logic                     err_oc_n,
   output logic                     stage_en,
   output logic                     pop_start
);
   localparam int TEMP_MAX     = (1 << (TEMP_W - 1)) - 1;
   localparam int MUTE_LATENCY = SYNC_DEPTH + 1;

   if (!(T_CLR < T_WARN && T_WARN < T_SHUT)) begin : g_bad_order
      $error("amp_guard: need T_CLR < T_WARN < T_SHUT");
   end
   if (T_SHUT > TEMP_MAX) begin : g_bad_range
      $error("amp_guard: T_SHUT does not fit TEMP_W");
   end
   if (OC_CONFIRM < 2) begin : g_bad_confirm
      $error("amp_guard: OC_CONFIRM must be at least 2");
   end
   if (RST_MIN_CYC < 1 || UNMUTE_DLY_CYC < 1) begin : g_bad_timing
      $error("amp_guard: timing parameters must be positive");
   end
   if (MUTE_LATENCY > MUTE_MAX_CYC) begin : g_bad_mute
      $error("amp_guard: mute path slower than its budget");
   end

   therm_flags_t tflags;
   logic         rst_act;
   logic         mute_s;
   logic         mute_act;
   logic         oc_lat;

   amp_thermal #(
      .TEMP_W(TEMP_W), .T_WARN(T_WARN), .T_SHUT(T_SHUT), .T_CLR(T_CLR)
   ) u_therm (
      .clk(clk), .arst_n(arst_n), .temp_c(temp_c), .flags(tflags)
   );

   amp_rst_qual #(.MIN_LOW(RST_MIN_CYC)) u_rstq (
      .clk(clk), .arst_n(arst_n), .pdn_n(pdn_n), .rst_act(rst_act)
   );

   amp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_mute_sync (
      .clk(clk), .arst_n(arst_n), .d(mute_n), .q(mute_s)
   );
   assign mute_act = ~mute_s;

   amp_oc_guard #(.CONFIRM(OC_CONFIRM)) u_oc (
      .clk(clk), .arst_n(arst_n), .oc_flag(oc_flag),
      .rst_act(rst_act), .mute_act(mute_act), .oc_lat(oc_lat)
   );

   amp_stage_seq #(.DLY(UNMUTE_DLY_CYC)) u_seq (
      .clk(clk), .arst_n(arst_n), .rst_act(rst_act), .mute_act(mute_act),
      .oc_lat(oc_lat), .shut(tflags.shut),
      .stage_en(stage_en), .pop_start(pop_start)
   );

   assign err_warn_n = ~tflags.warn;
   assign err_shut_n = ~tflags.shut;
   assign err_oc_n   = ~oc_lat;
endmodule

// File: rtl/amp_guard_chk.sv
`timescale 1ns/1ps
module amp_guard_chk #(
   parameter int TEMP_W         = 9,
   parameter int T_WARN         = 135,
   parameter int T_SHUT         = 150,
   parameter int T_CLR          = 120,
   parameter int UNMUTE_DLY_CYC = 11289600
) (
   input logic                     clk,
   input logic                     arst_n,
   input logic signed [TEMP_W-1:0] temp_c,
   input logic                     mute_n,
   input logic                     rst_act,
   input logic                     mute_act,
   input logic                     err_warn_n,
   input logic                     err_shut_n,
   input logic                     err_oc_n,
   input logic                     stage_en,
   input logic                     pop_start
);
   logic [1:0]  alive;
   logic [31:0] since_rst;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         alive     <= '0;
         since_rst <= '0;
      end else begin
         if (alive != 2'd3) alive <= alive + 2'd1;
         if (rst_act) since_rst <= '0;
         else if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 32'd1;
      end
   end

   a_r1_warn_trip: assert property (@(posedge clk) disable iff (!arst_n)
      (alive == 2'd3 && $past(temp_c, 2) > T_WARN) |-> !err_warn_n);

   a_r2_shut_trip: assert property (@(posedge clk) disable iff (!arst_n)
      (alive == 2'd3 && $past(temp_c, 2) > T_SHUT) |-> !err_shut_n);

   a_r2_shut_stops_stage: assert property (@(posedge clk) disable iff (!arst_n)
      !err_shut_n |=> !stage_en);

   a_r3_warn_release: assert property (@(posedge clk) disable iff (!arst_n)
      (alive == 2'd3 && $rose(err_warn_n)) |-> $past(temp_c, 2) < T_CLR);

   a_r3_shut_release: assert property (@(posedge clk) disable iff (!arst_n)
      (alive == 2'd3 && $rose(err_shut_n)) |-> $past(temp_c, 2) < T_CLR);

   a_r6_oc_stops_stage: assert property (@(posedge clk) disable iff (!arst_n)
      !err_oc_n |=> !stage_en);

   a_r6_oc_clear_cause: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(err_oc_n) |-> ($past(rst_act) || !$past(mute_act)));

   a_r7_rst_clears_oc: assert property (@(posedge clk) disable iff (!arst_n)
      rst_act |=> err_oc_n);

   a_r9_settle_delay: assert property (@(posedge clk) disable iff (!arst_n)
      stage_en |-> since_rst >= 32'(UNMUTE_DLY_CYC));

   a_r10_mute_latency: assert property (@(posedge clk) disable iff (!arst_n)
      (!$past(mute_n) && !$past(mute_n, 2) && !$past(mute_n, 3)) |-> !stage_en);

   a_r11_pop_on_rise: assert property (@(posedge clk) disable iff (!arst_n)
      pop_start |-> (stage_en && !$past(stage_en)));

   a_r11_rise_has_pop: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(stage_en) |-> pop_start);
endmodule

bind amp_guard amp_guard_chk #(
   .TEMP_W(TEMP_W), .T_WARN(T_WARN), .T_SHUT(T_SHUT), .T_CLR(T_CLR),
   .UNMUTE_DLY_CYC(UNMUTE_DLY_CYC)
) u_chk (
   .clk(clk), .arst_n(arst_n), .temp_c(temp_c), .mute_n(mute_n),
   .rst_act(rst_act), .mute_act(mute_act),
   .err_warn_n(err_warn_n), .err_shut_n(err_shut_n), .err_oc_n(err_oc_n),
   .stage_en(stage_en), .pop_start(pop_start)
);

// File: tb/sim_amp_guard.sv
`timescale 1ns/1ps
module sim_amp_guard;
   localparam int TEMP_W = 9;
   localparam int MINC   = 6;
   localparam int DLY    = 40;

   logic                     clk = 1'b0;
   logic                     arst_n;
   logic signed [TEMP_W-1:0] temp_c;
   logic                     oc_flag, pdn_n, mute_n;
   logic                     err_warn_n, err_shut_n, err_oc_n, stage_en, pop_start;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done     = 1'b0;

   always #2.5 clk = ~clk;

   amp_guard #(
      .TEMP_W(TEMP_W), .RST_MIN_CYC(MINC), .UNMUTE_DLY_CYC(DLY)
   ) u0 (
      .clk(clk), .arst_n(arst_n), .temp_c(temp_c), .oc_flag(oc_flag),
      .pdn_n(pdn_n), .mute_n(mute_n), .err_warn_n(err_warn_n),
      .err_shut_n(err_shut_n), .err_oc_n(err_oc_n), .stage_en(stage_en),
      .pop_start(pop_start)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset_state;
      tick(1);
      chk("R12", "err_warn_n", err_warn_n, 1);
      chk("R12", "err_shut_n", err_shut_n, 1);
      chk("R12", "err_oc_n",   err_oc_n,   1);
      chk("R12", "stage_en",   stage_en,   0);
      chk("R12", "pop_start",  pop_start,  0);
   endtask

   task automatic t_settle;
      pdn_n  = 1'b1;
      mute_n = 1'b1;
      tick(DLY + 3);
      chk("R9", "stage_en before delay end", stage_en, 0);
      tick(1);
      chk("R9", "stage_en after delay", stage_en, 1);
      chk("R11", "pop_start on rise", pop_start, 1);
      tick(1);
      chk("R11", "pop_start one cycle", pop_start, 0);
   endtask

   task automatic t_mute;
      mute_n = 1'b0;
      tick(2);
      chk("R10", "stage_en two cycles in", stage_en, 1);
      tick(1);
      chk("R10", "stage_en three cycles in", stage_en, 0);
      mute_n = 1'b1;
      tick(3);
      chk("R11", "stage_en back after unmute", stage_en, 1);
      chk("R11", "pop_start after unmute", pop_start, 1);
      tick(1);
   endtask

   task automatic t_thermal;
      temp_c = 9'sd135;
      tick(4);
      chk("R1", "warn at equal threshold", err_warn_n, 1);
      temp_c = 9'sd140;
      tick(2);
      chk("R1", "warn above threshold", err_warn_n, 0);
      chk("R1", "shut not yet", err_shut_n, 1);
      tick(1);
      chk("R1", "stage stays on with warning", stage_en, 1);
      temp_c = 9'sd155;
      tick(2);
      chk("R2", "shut above threshold", err_shut_n, 0);
      tick(1);
      chk("R2", "stage off on shutdown", stage_en, 0);
      temp_c = 9'sd125;
      tick(4);
      chk("R4", "warn held in band", err_warn_n, 0);
      chk("R4", "shut held in band", err_shut_n, 0);
      chk("R4", "stage off in band", stage_en, 0);
      temp_c = 9'sd120;
      tick(4);
      chk("R4", "shut held at release value", err_shut_n, 0);
      temp_c = 9'sd119;
      tick(2);
      chk("R3", "warn released", err_warn_n, 1);
      chk("R3", "shut released", err_shut_n, 1);
      tick(1);
      chk("R3", "stage back on", stage_en, 1);
      chk("R11", "pop on thermal recovery", pop_start, 1);
      temp_c = 9'sd136;
      tick(2);
      chk("R1", "warn at 136", err_warn_n, 0);
      temp_c = -9'sd30;
      tick(2);
      chk("R3", "warn released at negative", err_warn_n, 1);
      temp_c = 9'sd25;
      tick(2);
   endtask

   task automatic t_oc_glitch;
      oc_flag = 1'b1;
      tick(1);
      oc_flag = 1'b0;
      tick(8);
      chk("R5", "single-cycle glitch ignored", err_oc_n, 1);
      chk("R5", "stage unaffected by glitch", stage_en, 1);
   endtask

   task automatic t_oc_latch;
      oc_flag = 1'b1;
      tick(3);
      chk("R5", "err_oc_n before confirm", err_oc_n, 1);
      tick(1);
      chk("R5", "err_oc_n after confirm", err_oc_n, 0);
      tick(1);
      chk("R6", "stage off on over-current", stage_en, 0);
      oc_flag = 1'b0;
      tick(20);
      chk("R6", "fault stays latched", err_oc_n, 0);
      chk("R6", "stage stays off", stage_en, 0);
      mute_n = 1'b0;
      tick(5);
      chk("R6", "still latched while muted", err_oc_n, 0);
      mute_n = 1'b1;
      tick(3);
      chk("R6", "cleared by mute release", err_oc_n, 1);
      chk("R6", "stage not yet on", stage_en, 0);
      tick(1);
      chk("R6", "stage on after clear", stage_en, 1);
      chk("R11", "pop after clear", pop_start, 1);
      tick(2);
   endtask

   task automatic t_oc_reset;
      int drops = 0;
      oc_flag = 1'b1;
      tick(6);
      oc_flag = 1'b0;
      chk("R7", "latched before power-down", err_oc_n, 0);
      pdn_n = 1'b0;
      tick(MINC);
      pdn_n = 1'b1;
      tick(6);
      chk("R7", "power-down clears fault", err_oc_n, 1);
      chk("R8", "stage held off after accepted pulse", stage_en, 0);
      tick(DLY + 4);
      chk("R9", "stage on after settle", stage_en, 1);
      pdn_n = 1'b0;
      tick(MINC - 1);
      pdn_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         tick(1);
         if (!stage_en) drops++;
      end
      chk("R8", "short pulse ignored (cycles off)", drops, 0);
   endtask

   initial begin
      arst_n  = 1'b0;
      temp_c  = 9'sd25;
      oc_flag = 1'b0;
      pdn_n   = 1'b0;
      mute_n  = 1'b0;
      tick(3);
      chk("R12", "stage_en in reset", stage_en, 0);
      chk("R12", "err_oc_n in reset", err_oc_n, 1);
      arst_n = 1'b1;
      t_reset_state();
      t_settle();
      t_mute();
      t_thermal();
      t_oc_glitch();
      t_oc_latch();
      t_oc_reset();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule